// File: doc/BRIEF.md
# Reset Cause Collector

This block merges the chip's reset requests into a single synchronous chip reset and keeps a sticky record of which requests caused it. It watches an external reset pin, a watchdog timeout, a serial break detector and a brownout detector, all asynchronous to the clock. It also accepts a software reset request written over a small register bus. The external pin, the watchdog and the break detector each count only when their enable input is 1. The brownout detector counts unless its disable input is 1. The asynchronous requests pass through a multi-flop synchronizer before they can act.

Power-on is the block's own asynchronous reset. It loads the cause register with the power-on and brownout marks and clears every other mark. Every other reset event adds its own mark on top of the marks already held. Software reads the register at address 0 and clears a mark by writing 0 to its bit. Once the last request goes away, the chip reset output is held asserted for a fixed number of cycles.

Top module: `rst_cause_unit`

## Requirements
- R1: While `pwr_on_i` is 1, and after it is released, the cause register reads 0x30. The bit layout is: bit 0 external pin, bit 1 software, bit 2 watchdog, bit 3 break, bit 4 power-on, bit 5 brownout. Power-on clears any mark set before it.
- R2: An enabled asynchronous request asserts `chip_rst_o` and sets its own bit in the cause register. The external pin needs `cfg_ext_en_i`=1, the watchdog `cfg_wdt_en_i`=1, break `cfg_brk_en_i`=1, and brownout `cfg_bod_dis_i`=0.
- R3: A request whose gate is off causes no chip reset and sets no bit.
- R4: Marks are sticky. A later non-power-on reset adds its bit and keeps the bits already set.
- R5: A write to address 0 clears each bit whose written value is 0. A written 1 leaves that bit unchanged.
- R6: Writing 1 to bit 0 at address 1 requests a software reset. This asserts `chip_rst_o` and sets bit 1. The request clears itself after one cycle, so address 1 then reads 0.
- R7: `chip_rst_o` stays 1 for exactly `STRETCH_CYCLES` clock cycles after the last cycle in which a synchronized, enabled request was active, or after power-on is released.
- R8: If the external pin is enabled and still held when power-on ends, bit 0 becomes set in addition to 0x30.
- R9: Requests that are active together all set their bits in the same event.
- R10: Bits 7 and 6 of every read are 0, and writes to those bits have no effect.
- R11: `chip_rst_o` is 1 whenever `pwr_on_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_on_i | input | 1 | Power-on detect, asynchronous, active high; resets the block |
| ext_rst_i | input | 1 | External reset pin, asynchronous, active high |
| wdt_to_i | input | 1 | Watchdog timeout request, asynchronous |
| brk_det_i | input | 1 | Serial break detected, asynchronous |
| bod_det_i | input | 1 | Brownout detected, asynchronous |
| cfg_ext_en_i | input | 1 | Lets the external pin cause resets |
| cfg_wdt_en_i | input | 1 | Lets the watchdog cause resets |
| cfg_brk_en_i | input | 1 | Lets a break cause resets |
| cfg_bod_dis_i | input | 1 | Blocks brownout resets when 1 |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0: cause register, 1: software request register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| chip_rst_o | output | 1 | Synchronous chip reset |

## Verification
The bench builds the block with its default parameters: two synchronizer flops and an 8-cycle stretch. With these values the length of the reset pulse has a small closed form: sync stages + stretch − 1 samples after an asynchronous request drops, and stretch + 1 samples from a software request. The bench checks the exact pulse length against that form. It sweeps each of the four asynchronous sources with its gate both open and closed. It also covers the combined cases: several requests at once, sticky accumulation, power-on with the pin held, and single-bit clears.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int FLAG_W = 6;
  localparam int DATA_W = 8;

  // cause register bit positions (software decodes these)
  localparam int B_EXT = 0;
  localparam int B_SW  = 1;
  localparam int B_WDT = 2;
  localparam int B_BRK = 3;
  localparam int B_POR = 4;
  localparam int B_BOD = 5;

  localparam logic [FLAG_W-1:0] POR_FLAGS = 6'b110000;

  // next cause value: written zeros clear, new events set (set wins)
  function automatic logic [FLAG_W-1:0] flag_next(
    input logic [FLAG_W-1:0] cur,
    input logic [FLAG_W-1:0] set,
    input logic              wr,
    input logic [FLAG_W-1:0] wdata
  );
    logic [FLAG_W-1:0] keep;
    keep = wr ? wdata : {FLAG_W{1'b1}};
    return (cur & keep) | set;
  endfunction

  // reset pulse length seen after an asynchronous request drops
  function automatic int async_pulse_len(input int stages, input int stretch);
    return stages + stretch - 1;
  endfunction
endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) sh <= '0;
      else       sh <= {sh[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
  parameter int STRETCH = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)              cnt_o <= LOAD;
    else if (hit_i)         cnt_o <= LOAD;
    else if (cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
  end

  assign active_o = (cnt_o != '0);
endmodule

// File: rtl/rcu_flags.sv
module rcu_flags
  import rcu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) flags_o <= POR_FLAGS;
    else       flags_o <= flag_next(flags_o, set_i, wr_i, wdata_i);
  end
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rcu_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              pwr_on_i,
  input  logic              ext_rst_i,
  input  logic              wdt_to_i,
  input  logic              brk_det_i,
  input  logic              bod_det_i,
  input  logic              cfg_ext_en_i,
  input  logic              cfg_wdt_en_i,
  input  logic              cfg_brk_en_i,
  input  logic              cfg_bod_dis_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              chip_rst_o
);
  localparam int CNT_W   = $clog2(STRETCH_CYCLES + 1);
  localparam int N_ASYNC = 4;

  // synchronized asynchronous requests: {bod, brk, wdt, ext}
  logic [N_ASYNC-1:0] req_raw, req_s;
  assign req_raw = {bod_det_i, brk_det_i, wdt_to_i, ext_rst_i};

  rcu_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (pwr_on_i),
    .d_i   (req_raw),
    .q_o   (req_s)
  );

  // bus decode
  logic flag_wr, ctrl_wr;
  assign flag_wr = bus_we_i & ~bus_addr_i;
  assign ctrl_wr = bus_we_i &  bus_addr_i;

  // software request: one-cycle pulse
  logic sw_req_q;
  always_ff @(posedge clk_i or posedge pwr_on_i) begin
    if (pwr_on_i)                    sw_req_q <= 1'b0;
    else if (ctrl_wr && bus_wdata_i[0]) sw_req_q <= 1'b1;
    else                             sw_req_q <= 1'b0;
  end

  // gated events, named for the checker
  logic [FLAG_W-1:0] set_vec;
  logic              any_hit;
  always_comb begin
    set_vec        = '0;
    set_vec[B_EXT] = req_s[0] & cfg_ext_en_i;
    set_vec[B_SW]  = sw_req_q;
    set_vec[B_WDT] = req_s[1] & cfg_wdt_en_i;
    set_vec[B_BRK] = req_s[2] & cfg_brk_en_i;
    set_vec[B_BOD] = req_s[3] & ~cfg_bod_dis_i;
  end
  assign any_hit = |set_vec;

  // reset stretch
  logic [CNT_W-1:0] cnt_q;
  logic             stretch_active;
  rcu_stretch #(.STRETCH(STRETCH_CYCLES), .CNT_W(CNT_W)) u_stretch (
    .clk_i    (clk_i),
    .rst_i    (pwr_on_i),
    .hit_i    (any_hit),
    .cnt_o    (cnt_q),
    .active_o (stretch_active)
  );

  assign chip_rst_o = pwr_on_i | any_hit | stretch_active;

  // cause register
  logic [FLAG_W-1:0] flags_q;
  rcu_flags u_flags (
    .clk_i   (clk_i),
    .rst_i   (pwr_on_i),
    .set_i   (set_vec),
    .wr_i    (flag_wr),
    .wdata_i (bus_wdata_i[FLAG_W-1:0]),
    .flags_o (flags_q)
  );

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:FLAG_W];

  // read mux; reserved bits are zero
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i) bus_rdata_o[0]        = sw_req_q;
    else            bus_rdata_o[FLAG_W-1:0] = flags_q;
  end
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker
  import rcu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic              clk_i,
  input logic              pwr_on_i,
  input logic              cfg_wdt_en_i,
  input logic              bus_we_i,
  input logic              bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              chip_rst_o,
  input logic [FLAG_W-1:0] flags_q,
  input logic [FLAG_W-1:0] set_vec,
  input logic              any_hit,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              sw_req_q
);
  always_ff @(posedge clk_i) begin
    if (pwr_on_i) begin
      assert_por_value_R1: assert (flags_q == POR_FLAGS);
      assert_rst_during_por_R11: assert (chip_rst_o);
    end
    assert_reserved_zero_R10: assert (bus_rdata_o[DATA_W-1:FLAG_W] == '0);
  end

  assert_event_sets_flag_R2: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  assert_wdt_gated_R3: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    $rose(flags_q[B_WDT]) |-> $past(cfg_wdt_en_i));

  assert_clear_only_by_write_R5: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    ((~flags_q & $past(flags_q)) != '0) |-> $past(bus_we_i && !bus_addr_i));

  assert_sw_self_clear_R6: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    (sw_req_q && !(bus_we_i && bus_addr_i && bus_wdata_i[0])) |=> !sw_req_q);

  assert_hit_resets_R7: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    any_hit |-> chip_rst_o);

  assert_countdown_R7: assert property (@(posedge clk_i) disable iff (pwr_on_i)
    (!any_hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

bind rst_cause_unit rcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .pwr_on_i     (pwr_on_i),
  .cfg_wdt_en_i (cfg_wdt_en_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .chip_rst_o   (chip_rst_o),
  .flags_q      (flags_q),
  .set_vec      (set_vec),
  .any_hit      (any_hit),
  .cnt_q        (cnt_q),
  .sw_req_q     (sw_req_q)
);

// File: tb/rst_cause_unit_tb.sv
module rst_cause_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int STRETCH    = 8;

  logic clk = 1'b0;
  logic pwr_on, ext_rst, wdt_to, brk_det, bod_det;
  logic ext_en, wdt_en, brk_en, bod_dis;
  logic we, addr;
  logic [7:0] wdata, rdata;
  logic chip_rst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_unit #(.SYNC_STAGES(SYNC), .STRETCH_CYCLES(STRETCH)) u_dut (
    .clk_i(clk), .pwr_on_i(pwr_on), .ext_rst_i(ext_rst), .wdt_to_i(wdt_to),
    .brk_det_i(brk_det), .bod_det_i(bod_det), .cfg_ext_en_i(ext_en),
    .cfg_wdt_en_i(wdt_en), .cfg_brk_en_i(brk_en), .cfg_bod_dis_i(bod_dis),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .chip_rst_o(chip_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // count reset samples at the following negedges (optionally including now)
  task automatic count_rst(input bit now, output int n);
    n = 0;
    if (now && chip_rst) n++;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (chip_rst) n++;
    end
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: ext_rst = v;
      1: wdt_to  = v;
      2: brk_det = v;
      default: bod_det = v;
    endcase
  endtask

  task automatic set_gate(input int s, input bit open);
    ext_en = 1'b1; wdt_en = 1'b1; brk_en = 1'b1; bod_dis = 1'b0;
    case (s)
      0: ext_en  = open;
      1: wdt_en  = open;
      2: brk_en  = open;
      default: bod_dis = !open;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    int bitpos[4] = '{0, 2, 3, 5};
    pwr_on = 1'b1; ext_rst = 0; wdt_to = 0; brk_det = 0; bod_det = 0;
    ext_en = 1; wdt_en = 1; brk_en = 1; bod_dis = 0;
    we = 0; addr = 0; wdata = '0;
    repeat (3) @(negedge clk);
    bus_read(0, rd);
    check("R1 por value", rd, 8'h30);
    check("R11 reset during power-on", chip_rst, 1);
    pwr_on = 1'b0;
    count_rst(1, n);
    check("R7 stretch after power-on", n, STRETCH);
    bus_read(0, rd);
    check("R1 value after release", rd, 8'h30);

    // clear semantics and reserved bits
    bus_write(0, 8'h00);
    bus_read(0, rd);
    check("R5 write zero clears", rd, 8'h00);
    bus_write(0, 8'hFF);
    bus_read(0, rd);
    check("R5 write one no effect", rd, 8'h00);
    check("R10 reserved bits zero", rd[7:6], 0);

    // sweep each asynchronous source with gate open and closed
    for (int s = 0; s < 4; s++) begin
      for (int g = 0; g < 2; g++) begin
        set_gate(s, g[0]);
        @(negedge clk); set_src(s, 1'b1);
        repeat (5) @(negedge clk);
        set_src(s, 1'b0);
        count_rst(0, n);
        check(g ? "R2 pulse length" : "R3 gated pulse", n,
              g ? rcu_pkg::async_pulse_len(SYNC, STRETCH) : 0);
        bus_read(0, rd);
        check(g ? "R2 source flag" : "R3 gated flag", rd, g ? (1 << bitpos[s]) : 0);
        bus_write(0, 8'h00);
      end
    end
    set_gate(0, 1'b1);

    // software request
    bus_write(1, 8'h01);
    count_rst(1, n);
    check("R6 sw reset pulse", n, STRETCH + 1);
    bus_read(1, rd);
    check("R6 request self-clears", rd, 8'h00);
    bus_read(0, rd);
    check("R6 sw flag", rd, 8'h02);

    // sticky: add an external event on top
    @(negedge clk); ext_rst = 1'b1;
    repeat (4) @(negedge clk); ext_rst = 1'b0;
    count_rst(0, n);
    bus_read(0, rd);
    check("R4 sticky accumulate", rd, 8'h03);
    bus_write(0, 8'hFE);
    bus_read(0, rd);
    check("R5 single bit clear", rd, 8'h02);
    bus_write(0, 8'h00);

    // simultaneous sources
    @(negedge clk); wdt_to = 1'b1; brk_det = 1'b1;
    repeat (4) @(negedge clk); wdt_to = 1'b0; brk_det = 1'b0;
    count_rst(0, n);
    bus_read(0, rd);
    check("R9 simultaneous flags", rd, 8'h0C);

    // power-on clears earlier marks; pin held beyond power-on end
    @(negedge clk); pwr_on = 1'b1; ext_rst = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(0, rd);
    check("R1 power-on clears others", rd, 8'h30);
    pwr_on = 1'b0;
    repeat (5) @(negedge clk);
    ext_rst = 1'b0;
    count_rst(0, n);
    bus_read(0, rd);
    check("R8 pin held after power-on", rd, 8'h31);
    check("R10 reserved after events", rd[7:6], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule